// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the bus-side command logic of a byte-wide, block-erasable nonvolatile memory. A host reaches it over an asynchronous SRAM-style bus (active-low chip enable, output enable, write enable) plus an active-low reset/power-down pin and a write-protect pin. All of these are sampled on a system clock. A bus write is taken on the clock edge where write enable is seen to have gone high while chip enable is low. Single-cycle commands choose what a read returns: array bytes, identifier codes or the status register. Byte write, block erase and lock-bit changes each need a setup cycle followed by a second cycle.

A small internal RAM of 32 blocks stands in for the cell array. A down-counter stands in for the internal program, erase and lock time, and it holds the busy/ready output low while it runs. Holding power-down low long enough puts the block into deep power-down. That aborts any operation in flight, fills the affected bytes with a known pattern, and on exit brings the command state back to array read with a clean status. Recovery and wake-up windows follow the exit.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After system reset, and after leaving deep power-down, reads return array data, and the status register reads 80h once selected with command 70h.
- R2: `dout_oe` is high only while `ce_n`=0, `oe_n`=0, `we_n`=1 and `pd_n`=1. Otherwise the data bus is released, even while an operation runs.
- R3: Command FFh selects array read, 90h selects identifier read and 70h selects status read. In identifier mode, offset 0 within a block returns `ID_MFR`, offset 1 returns `ID_DEV`, offset 2 returns the block's lock bit in bit 0, and other offsets return 00h.
- R4: Command 40h or 10h followed by a data cycle programs that address, and the byte becomes old AND new.
- R5: Command 20h followed by D0h sets every byte of the addressed block to FFh. 20h followed by any other byte leaves memory unchanged and sets status bits 5 and 4.
- R6: Command 60h then 01h sets the addressed block's lock bit. 60h then D0h clears all lock bits.
- R7: At the second cycle, `wp`=1 blocks the change and sets status bit 3 plus the operation's bit (bit 4 for write/lock-set, bit 5 for erase/lock-clear). A locked target block blocks a write or erase and sets bit 1 plus the operation's bit.
- R8: Status bit 7 is 1 when ready. Command 50h clears bits 5, 4, 3 and 1. Bits 6, 2 and 0 read as 0.
- R9: While busy, every bus write is ignored. Deselecting the chip does not stop an operation that is running.
- R10: A `pd_n` low pulse shorter than `PD_MIN` cycles changes nothing. A pulse of `PD_MIN` cycles or more enters deep power-down. An operation still running at that point is aborted: its byte, or its whole block, becomes `FILL`, and `rdy` stays low for `T_ABORT` cycles. On exit, `rdy` is high.
- R11: After `pd_n` returns high from deep power-down, bus writes are ignored for `T_RECOV` cycles and the bus stays released for `T_WAKE` cycles.
- R12: `rdy` goes low on the edge that accepts the second cycle and stays low for exactly `T_WRITE`, `T_ERASE` or `T_LOCK` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; the command is taken on its rise |
| pd_n | input | 1 | Reset/power-down, active low |
| wp | input | 1 | Write protect (program voltage too low) |
| addr | input | BLK_W+OFF_W | Byte address; upper BLK_W bits select the block |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Drive enable for `dout`; low means high impedance |
| rdy | output | 1 | Ready (1) / busy (0) |

## Verification
A behavioural model in the bench follows every clock and compares bus enable, read data and ready on each cycle. That comparison runs across several kinds of traffic: plain mode switches, programs that pile zeros onto an already-written byte, erases of locked and unlocked blocks, and sequences with a wrong confirm byte. Protected attempts are told apart from locked attempts by their distinct status codes, and the memory read-back afterwards confirms that neither one changed any byte. Power-down pulses of both lengths are applied in the middle of an operation. The short pulse must let the program land with its AND result, and the long pulse must leave the fill pattern, so the two outcomes show which path was taken. Commands issued just after the exit show whether the recovery window is honoured.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int BLK_W   = 5,
  parameter int OFF_W   = 3,
  parameter int PD_MIN  = 20,
  parameter int T_WRITE = 24,
  parameter int T_ERASE = 48,
  parameter int T_LOCK  = 8,
  parameter int T_ABORT = 5,
  parameter int T_RECOV = 4,
  parameter int T_WAKE  = 3,
  parameter logic [7:0] ID_MFR = 8'hA7,
  parameter logic [7:0] ID_DEV = 8'h5E,
  parameter logic [7:0] FILL   = 8'h00
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   oe_n,
  input  logic                   we_n,
  input  logic                   pd_n,
  input  logic                   wp,
  input  logic [BLK_W+OFF_W-1:0] addr,
  input  logic [7:0]             din,
  output logic [7:0]             dout,
  output logic                   dout_oe,
  output logic                   rdy
);
  localparam int AW   = BLK_W + OFF_W;
  localparam int NB   = 1 << AW;
  localparam int NOFF = 1 << OFF_W;
  localparam int NBLK = 1 << BLK_W;
  localparam int CW   = $clog2(PD_MIN + T_WRITE + T_ERASE + T_LOCK + T_ABORT + T_RECOV + T_WAKE + 2);

  typedef enum logic [1:0] {M_ARR, M_ID, M_STS} mode_t;
  typedef enum logic [1:0] {Q_IDLE, Q_WR, Q_ER, Q_LK} seq_t;
  typedef enum logic [1:0] {O_WR, O_ER, O_SETLK, O_CLRLK} op_t;

  logic [7:0]    mem [NB];
  logic [NBLK-1:0] lock;
  mode_t         mode;
  seq_t          seq;
  op_t           op;
  logic [AW-1:0] op_a;
  logic [7:0]    op_d;
  logic [3:0]    err;
  logic [CW-1:0] busy, abrt, pdc, recov, wake;
  logic          we_q;

  wire              busy_any   = (busy != '0) || (abrt != '0);
  wire              deep       = (pdc == CW'(PD_MIN));
  wire              enter_deep = !pd_n && (pdc == CW'(PD_MIN - 1));
  wire              leave_deep = pd_n && deep;
  wire              wr_ev      = !we_q && we_n && !ce_n && pd_n && !deep && (recov == '0) && !busy_any;
  wire [BLK_W-1:0]  blk        = addr[AW-1:OFF_W];
  wire [OFF_W-1:0]  off        = addr[OFF_W-1:0];
  wire [BLK_W-1:0]  op_blk     = op_a[AW-1:OFF_W];
  wire              sts_sel    = (mode == M_STS);
  wire              arr_sel    = (mode == M_ARR);
  wire [7:0]        status     = {!busy_any, 1'b0, err[3], err[2], err[1], 1'b0, err[0], 1'b0};

  logic [7:0] id_val;
  always_comb begin
    if (off == OFF_W'(0))      id_val = ID_MFR;
    else if (off == OFF_W'(1)) id_val = ID_DEV;
    else if (off == OFF_W'(2)) id_val = {7'b0, lock[blk]};
    else                       id_val = 8'h00;
  end

  assign dout    = sts_sel ? status : (arr_sel ? mem[addr] : id_val);
  assign dout_oe = !ce_n && !oe_n && we_n && pd_n && !deep && (wake == '0);
  assign rdy     = !busy_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
      lock  <= '0;
      mode  <= M_ARR;
      seq   <= Q_IDLE;
      op    <= O_WR;
      op_a  <= '0;
      op_d  <= '0;
      err   <= '0;
      busy  <= '0;
      abrt  <= '0;
      pdc   <= '0;
      recov <= '0;
      wake  <= '0;
      we_q  <= 1'b1;
    end else begin
      we_q <= we_n;
      if (!pd_n) begin
        if (!deep) pdc <= pdc + 1'b1;
      end else begin
        pdc <= '0;
      end
      if (recov != '0) recov <= recov - 1'b1;
      if (wake != '0)  wake  <= wake - 1'b1;
      if (abrt != '0)  abrt  <= abrt - 1'b1;

      if (enter_deep && busy != '0) begin
        busy <= '0;
        abrt <= CW'(T_ABORT);
        case (op)
          O_WR: mem[op_a] <= FILL;
          O_ER: for (int i = 0; i < NOFF; i++) mem[{op_blk, OFF_W'(i)}] <= FILL;
          default: ;
        endcase
      end else if (busy != '0) begin
        busy <= busy - 1'b1;
        if (busy == CW'(1)) begin
          case (op)
            O_WR:    mem[op_a] <= mem[op_a] & op_d;
            O_ER:    for (int i = 0; i < NOFF; i++) mem[{op_blk, OFF_W'(i)}] <= 8'hFF;
            O_SETLK: lock[op_blk] <= 1'b1;
            O_CLRLK: lock <= '0;
          endcase
        end
      end

      if (leave_deep) begin
        mode  <= M_ARR;
        seq   <= Q_IDLE;
        err   <= '0;
        busy  <= '0;
        abrt  <= '0;
        recov <= CW'(T_RECOV);
        wake  <= CW'(T_WAKE);
      end else if (wr_ev) begin
        case (seq)
          Q_IDLE: begin
            case (din)
              8'hFF: mode <= M_ARR;
              8'h90: mode <= M_ID;
              8'h70: mode <= M_STS;
              8'h50: err  <= '0;
              8'h40, 8'h10: begin seq <= Q_WR; mode <= M_STS; end
              8'h20: begin seq <= Q_ER; mode <= M_STS; end
              8'h60: begin seq <= Q_LK; mode <= M_STS; end
              default: ;
            endcase
          end
          Q_WR: begin
            seq <= Q_IDLE;
            if (wp)             err <= err | 4'b0110;
            else if (lock[blk]) err <= err | 4'b0101;
            else begin
              op <= O_WR; op_a <= addr; op_d <= din; busy <= CW'(T_WRITE);
            end
          end
          Q_ER: begin
            seq <= Q_IDLE;
            if (din != 8'hD0)   err <= err | 4'b1100;
            else if (wp)        err <= err | 4'b1010;
            else if (lock[blk]) err <= err | 4'b1001;
            else begin
              op <= O_ER; op_a <= addr; busy <= CW'(T_ERASE);
            end
          end
          Q_LK: begin
            seq <= Q_IDLE;
            if (din == 8'h01) begin
              if (wp) err <= err | 4'b0110;
              else begin op <= O_SETLK; op_a <= addr; busy <= CW'(T_LOCK); end
            end else if (din == 8'hD0) begin
              if (wp) err <= err | 4'b1010;
              else begin op <= O_CLRLK; op_a <= addr; busy <= CW'(T_LOCK); end
            end else begin
              err <= err | 4'b1100;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int PD_MIN = 20,
  parameter int T_WAKE = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       pd_n,
  input logic       dout_oe,
  input logic       rdy,
  input logic       sts_sel,
  input logic       arr_sel,
  input logic [3:0] err
);
  int lowcnt;
  int wk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowcnt <= 0;
      wk     <= 0;
    end else begin
      if (!pd_n) lowcnt <= (lowcnt < PD_MIN) ? lowcnt + 1 : lowcnt;
      else       lowcnt <= 0;
      if (pd_n && lowcnt == PD_MIN) wk <= T_WAKE;
      else if (wk != 0)             wk <= wk - 1;
    end
  end

  p_bus_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (!ce_n && !oe_n && we_n && pd_n));

  p_exit_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && lowcnt == PD_MIN) |=> (err == 4'b0 && arr_sel));

  p_exit_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && lowcnt == PD_MIN) |=> rdy);

  p_wake_float_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wk != 0) |-> !dout_oe);

  p_busy_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && pd_n && lowcnt < PD_MIN) |=> ($stable(err) && $stable(sts_sel)));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.PD_MIN(PD_MIN), .T_WAKE(T_WAKE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .pd_n(pd_n),
  .dout_oe(dout_oe), .rdy(rdy), .sts_sel(sts_sel), .arr_sel(arr_sel), .err(err)
);

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
  localparam int PD_MIN = 20, T_WRITE = 24, T_ERASE = 48, T_LOCK = 8;
  localparam int T_ABORT = 5, T_RECOV = 4, T_WAKE = 3;
  localparam int ID_M = 8'hA7, ID_D = 8'h5E, FILLV = 8'h00;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1, pd_n = 1, wp = 0;
  logic [7:0] addr = 0, din = 0;
  logic [7:0] dout;
  logic dout_oe, rdy;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .pd_n(pd_n),
    .wp(wp), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .rdy(rdy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int  r_mem [256];
  bit  r_lock [32];
  int  r_mode, r_seq, r_op, r_a, r_d;
  bit  e_er, e_wr, e_wp, e_lk;
  int  r_busy, r_abort, r_low, r_recov, r_wake;
  bit  r_weq;

  function automatic int r_status();
    return ((r_busy == 0 && r_abort == 0) ? 8'h80 : 0) + (e_er ? 8'h20 : 0) +
           (e_wr ? 8'h10 : 0) + (e_wp ? 8'h08 : 0) + (e_lk ? 8'h02 : 0);
  endfunction

  task automatic r_start(input int kind, input int len);
    r_op = kind; r_a = addr; r_d = din; r_busy = len;
  endtask

  task automatic r_step();
    bit ev, going, leaving;
    int b;
    if (!rst_n) begin
      foreach (r_mem[i]) r_mem[i] = 8'hFF;
      foreach (r_lock[i]) r_lock[i] = 0;
      r_mode = 0; r_seq = 0; r_op = 0; r_a = 0; r_d = 0;
      {e_er, e_wr, e_wp, e_lk} = 0;
      r_busy = 0; r_abort = 0; r_low = 0; r_recov = 0; r_wake = 0; r_weq = 1;
      return;
    end
    ev = !r_weq && we_n && !ce_n && pd_n && r_low < PD_MIN && r_recov == 0 && r_busy == 0 && r_abort == 0;
    going = !pd_n && r_low == PD_MIN - 1;
    leaving = pd_n && r_low == PD_MIN;
    r_weq = we_n;
    if (!pd_n) begin if (r_low < PD_MIN) r_low++; end else r_low = 0;
    if (r_recov > 0) r_recov--;
    if (r_wake > 0) r_wake--;
    if (r_abort > 0) r_abort--;
    if (going && r_busy > 0) begin
      r_busy = 0; r_abort = T_ABORT;
      if (r_op == 0) r_mem[r_a] = FILLV;
      else if (r_op == 1) for (int k = 0; k < 8; k++) r_mem[(r_a / 8) * 8 + k] = FILLV;
    end else if (r_busy > 0) begin
      r_busy--;
      if (r_busy == 0) begin
        case (r_op)
          0: r_mem[r_a] = r_mem[r_a] & r_d;
          1: for (int k = 0; k < 8; k++) r_mem[(r_a / 8) * 8 + k] = 8'hFF;
          2: r_lock[r_a / 8] = 1;
          default: foreach (r_lock[i]) r_lock[i] = 0;
        endcase
      end
    end
    if (leaving) begin
      r_mode = 0; r_seq = 0; {e_er, e_wr, e_wp, e_lk} = 0;
      r_busy = 0; r_abort = 0; r_recov = T_RECOV; r_wake = T_WAKE;
    end else if (ev) begin
      b = addr / 8;
      if (r_seq == 0) begin
        case (din)
          8'hFF: r_mode = 0;
          8'h90: r_mode = 1;
          8'h70: r_mode = 2;
          8'h50: {e_er, e_wr, e_wp, e_lk} = 0;
          8'h40, 8'h10: begin r_seq = 1; r_mode = 2; end
          8'h20: begin r_seq = 2; r_mode = 2; end
          8'h60: begin r_seq = 3; r_mode = 2; end
          default: ;
        endcase
      end else if (r_seq == 1) begin
        r_seq = 0;
        if (wp) begin e_wr = 1; e_wp = 1; end
        else if (r_lock[b]) begin e_wr = 1; e_lk = 1; end
        else r_start(0, T_WRITE);
      end else if (r_seq == 2) begin
        r_seq = 0;
        if (din != 8'hD0) begin e_er = 1; e_wr = 1; end
        else if (wp) begin e_er = 1; e_wp = 1; end
        else if (r_lock[b]) begin e_er = 1; e_lk = 1; end
        else r_start(1, T_ERASE);
      end else begin
        r_seq = 0;
        if (din == 8'h01) begin
          if (wp) begin e_wr = 1; e_wp = 1; end else r_start(2, T_LOCK);
        end else if (din == 8'hD0) begin
          if (wp) begin e_er = 1; e_wp = 1; end else r_start(3, T_LOCK);
        end else begin e_er = 1; e_wr = 1; end
      end
    end
  endtask

  always @(posedge clk) begin
    int exp_d;
    bit exp_oe, exp_rdy;
    r_step();
    #1;
    if (rst_n && !done) begin
      exp_oe  = !ce_n && !oe_n && we_n && pd_n && r_low < PD_MIN && r_wake == 0;
      exp_rdy = (r_busy == 0 && r_abort == 0);
      if (r_mode == 2) exp_d = r_status();
      else if (r_mode == 0) exp_d = r_mem[addr];
      else case (addr % 8)
        0: exp_d = ID_M;
        1: exp_d = ID_D;
        2: exp_d = r_lock[addr / 8];
        default: exp_d = 0;
      endcase
      chk(dout_oe == exp_oe, "R2 bus enable", dout_oe, exp_oe);
      chk(rdy == exp_rdy, "R12 ready", rdy, exp_rdy);
      if (exp_oe) chk(dout == exp_d[7:0], "R3 read data", dout, exp_d);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cmd(input int a, input int d);
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 0; addr = a[7:0]; din = d[7:0];
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = a[7:0];
    @(posedge clk); #1;
    chk(dout_oe == 1 && dout == exp[7:0], tag, {dout_oe, dout}, {1'b1, exp[7:0]});
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rdy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic pdown(input int n);
    @(negedge clk); pd_n = 0;
    repeat (n) @(negedge clk);
    pd_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, 8'hFF, "R1 array after reset");
    cmd(0, 8'h70);
    rd(0, 8'h80, "R1 status after reset");
    // R4 / R12 byte write, AND semantics
    cmd(8'h09, 8'h40); cmd(8'h09, 8'h3C);
    chk(rdy == 0, "R12 busy after confirm", rdy, 0);
    wait_ready(n);
    chk(n == T_WRITE, "R12 write length", n, T_WRITE);
    cmd(0, 8'hFF); rd(8'h09, 8'h3C, "R4 first write");
    cmd(8'h09, 8'h10); cmd(8'h09, 8'h0F); wait_ready(n);
    cmd(0, 8'hFF); rd(8'h09, 8'h0C, "R4 write ANDs");
    // R3 identifier mode
    cmd(0, 8'h90);
    rd(8'h00, ID_M, "R3 id offset 0");
    rd(8'h01, ID_D, "R3 id offset 1");
    rd(8'h0A, 8'h00, "R3 lock clear");
    rd(8'h0B, 8'h00, "R3 id other offset");
    // R6 lock set, R7 locked write
    cmd(8'h08, 8'h60); cmd(8'h08, 8'h01);
    wait_ready(n);
    chk(n == T_LOCK, "R6 lock length", n, T_LOCK);
    cmd(0, 8'h90); rd(8'h0A, 8'h01, "R6 lock bit set");
    cmd(8'h0A, 8'h40); cmd(8'h0A, 8'h00);
    chk(rdy == 1, "R7 locked write not started", rdy, 1);
    rd(0, 8'h92, "R7 locked write status");
    cmd(0, 8'hFF); rd(8'h0A, 8'hFF, "R7 locked byte kept");
    // R8 clear status
    cmd(0, 8'h50); cmd(0, 8'h70); rd(0, 8'h80, "R8 clear status");
    // R7 locked erase, R6 clear locks
    cmd(8'h08, 8'h20); cmd(8'h08, 8'hD0);
    rd(0, 8'hA2, "R7 locked erase status");
    cmd(0, 8'h50); cmd(0, 8'h60); cmd(0, 8'hD0); wait_ready(n);
    cmd(0, 8'h90); rd(8'h0A, 8'h00, "R6 locks cleared");
    // R5 erase, R9 commands ignored while busy
    cmd(8'h08, 8'h20); cmd(8'h08, 8'hD0);
    cmd(0, 8'hFF);
    rd(0, 8'h00, "R9 busy status, command ignored");
    wait_ready(n);
    cmd(0, 8'hFF); rd(8'h09, 8'hFF, "R5 erased byte");
    // R5 bad confirm
    cmd(8'h09, 8'h40); cmd(8'h09, 8'h81); wait_ready(n);
    cmd(8'h08, 8'h20); cmd(8'h08, 8'h77);
    rd(0, 8'hB0, "R5 bad confirm status");
    cmd(0, 8'h50); cmd(0, 8'hFF); rd(8'h09, 8'h81, "R5 no change on bad confirm");
    // R7 write protect
    wp = 1;
    cmd(8'h12, 8'h40); cmd(8'h12, 8'h00);
    rd(0, 8'h98, "R7 protect status");
    wp = 0;
    cmd(0, 8'h50); cmd(0, 8'hFF); rd(8'h12, 8'hFF, "R7 protected byte kept");
    // R10 glitch
    cmd(8'h13, 8'h40); cmd(8'h13, 8'hF0);
    pdown(5); wait_ready(n);
    cmd(0, 8'hFF); rd(8'h13, 8'hF0, "R10 glitch ignored");
    // R10 abort of write, R11 recovery
    cmd(8'h21, 8'h40); cmd(8'h21, 8'h0F);
    pdown(PD_MIN + 5);
    ce_n = 0; oe_n = 0; addr = 8'h00;
    @(posedge clk); #1;
    chk(dout_oe == 0, "R11 wake float", dout_oe, 0);
    @(negedge clk); ce_n = 1; oe_n = 1;
    cmd(0, 8'h90);
    repeat (T_RECOV + T_WAKE) @(negedge clk);
    rd(8'h00, 8'hFF, "R11 command in recovery ignored");
    rd(8'h21, FILLV, "R10 aborted byte filled");
    cmd(0, 8'h70); rd(0, 8'h80, "R1 status after exit");
    // R10 abort of erase
    cmd(8'h28, 8'h20); cmd(8'h28, 8'hD0);
    pdown(PD_MIN + 2);
    repeat (T_RECOV + T_WAKE + 2) @(negedge clk);
    rd(8'h2A, FILLV, "R10 aborted block filled low");
    rd(8'h2F, FILLV, "R10 aborted block filled high");
    repeat (5) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule